// File: doc/BRIEF.md
# AES Inverse Cipher Round Unit

This block computes one round of AES decryption in the equivalent-inverse form. A 128-bit state and a 128-bit round key enter together. The state's rows are rotated back, every byte passes through the inverse substitution, each column is multiplied by the inverse mixing matrix, and the round key is XORed in as the very last step. Because the key addition comes after the column mix, callers must supply round keys that have already been passed through the inverse column mix. A single control bit selects the final-round variant, which omits the column mix and is used only for the last round of a decryption.

The result is 256 bits wide, which mirrors a wide destination register. The low 128 bits always carry the round output. The upper 128 bits follow a second control bit. In merge mode they take the upper half of the supplied prior destination value. In zero mode they are forced to zero. Inputs are accepted in any cycle where `in_valid` is high, and the registered result appears one clock later. There are no status or exception outputs.

Top module: `aes_inv_round`

## Requirements
- R1: A capture with `in_valid` high raises `out_valid` on the next clock edge; with `in_valid` low, `out_valid` is low on the next clock edge.
- R2: While `rst_n` is low, `out_valid` is low, whatever `in_valid` does.
- R3: With `in_final` = 0, the result's low half equals InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. Byte index 4c+r sits at bits 8(4c+r)+7 : 8(4c+r), which is row r and column c. The inverse row shift puts input column (c−r) mod 4 of row r into column c. The column mix multiplies in GF(2^8), modulo 0x11B, by the circulant matrix whose first row is 0E 0B 0D 09.
- R4: With `in_final` = 1, the column mix is skipped: the low half is InvSubBytes(InvShiftRows(state)) XOR key.
- R5: With `in_zero_upper` = 0, `out_result[255:128]` equals `in_prior[255:128]` as captured.
- R6: With `in_zero_upper` = 1, `out_result[255:128]` is zero.
- R7: The inverse substitution is the standard AES inverse S-box. An all-zero state with an all-zero key yields 0x52 in every byte, in both the normal and the final variant.
- R8: While `in_valid` is low, `out_result` holds its last value, even as the data inputs change.
- R9: The key is added last. For a fixed state, two keys differing by mask D give low halves that differ by exactly D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_valid | input | 1 | Capture the inputs on this edge |
| in_final | input | 1 | 1 selects the final-round variant (no column mix) |
| in_zero_upper | input | 1 | 1 zeroes the upper result half; 0 merges the prior upper half |
| in_state | input | 128 | Round input state |
| in_key | input | 128 | Round key, pre-mixed for the normal round |
| in_prior | input | 256 | Prior destination value |
| out_valid | output | 1 | Result valid, one clock after capture |
| out_result | output | 256 | Registered round result |

## Verification
On every cycle, the assertions check the one-cycle valid latency, the handling of the upper half in both the merge and the zero modes, and that the result holds while idle. They also check that a column with four equal bytes passes the inverse mix unchanged. Only the bench scenarios can show that the full round arithmetic is right. It compares each vector against a reference model that rebuilds the inverse S-box by inverting a forward S-box, and it checks the 0x52 known answer, the key-linearity property, and that reset overrides a pending capture.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

  localparam int BYTE_W    = 8;
  localparam int ROWS      = 4;
  localparam int COLS      = 4;
  localparam int BLOCK_W   = BYTE_W * ROWS * COLS;
  localparam int COL_W     = BYTE_W * ROWS;
  localparam int DEST_W    = 2 * BLOCK_W;

  // Multiply by x in GF(2^8) modulo 0x11B
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    gf_xtime = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  // Generic GF(2^8) multiply, shift-and-add
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    gf_mul = acc;
  endfunction

  // Multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    r = a;
    for (int i = 0; i < 6; i++) r = gf_mul(gf_mul(r, r), a);
    gf_inv = gf_mul(r, r);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    rotl8 = (a << n) | (a >> (8 - n));
  endfunction

  // Inverse of the S-box affine step
  function automatic logic [7:0] inv_affine(input logic [7:0] b);
    inv_affine = rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
  import aes_inv_pkg::*;
(
  input  logic [7:0] sub_in,
  output logic [7:0] sub_out
);

  always_comb begin
    sub_out = gf_inv(inv_affine(sub_in));
  end

endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol
  import aes_inv_pkg::*;
#(
  parameter logic [7:0] COEF0 = 8'h0E,
  parameter logic [7:0] COEF1 = 8'h0B,
  parameter logic [7:0] COEF2 = 8'h0D,
  parameter logic [7:0] COEF3 = 8'h09
) (
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);

  logic [7:0] b [ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_split
      assign b[r] = col_in[BYTE_W*r +: BYTE_W];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_comb begin
        col_out[BYTE_W*r +: BYTE_W] = gf_mul(b[r], COEF0)
                                    ^ gf_mul(b[(r+1)%ROWS], COEF1)
                                    ^ gf_mul(b[(r+2)%ROWS], COEF2)
                                    ^ gf_mul(b[(r+3)%ROWS], COEF3);
      end
    end
  endgenerate

  // Coefficients XOR to 1, so a column of four equal bytes is a fixed point
  always_comb begin
    if ((b[0] == b[1]) && (b[1] == b[2]) && (b[2] == b[3])) begin
      AST_UNIFORM_COLUMN: assert (col_out == col_in); // R3
    end
  end

endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
  import aes_inv_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_final,
  input  logic         in_zero_upper,
  input  logic [127:0] in_state,
  input  logic [127:0] in_key,
  input  logic [255:0] in_prior,
  output logic         out_valid,
  output logic [255:0] out_result
);

  localparam int NBYTES = ROWS * COLS;

  logic [BLOCK_W-1:0] shifted;
  logic [BLOCK_W-1:0] subbed;
  logic [BLOCK_W-1:0] mixed;
  logic [BLOCK_W-1:0] round_low;
  logic [BLOCK_W-1:0] upper_d;

  logic               valid_d, valid_q;
  logic [DEST_W-1:0]  res_d, res_q;

  // Inverse row shift: row r of column c comes from column (c-r) mod 4
  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign shifted[BYTE_W*(ROWS*c+r) +: BYTE_W] =
          in_state[BYTE_W*(ROWS*((c-r+COLS)%COLS)+r) +: BYTE_W];
      end
    end
  endgenerate

  // Inverse substitution, one lookup per byte
  generate
    for (genvar i = 0; i < NBYTES; i++) begin : g_sbox
      aes_inv_sbox u_sbox (
        .sub_in  (shifted[BYTE_W*i +: BYTE_W]),
        .sub_out (subbed[BYTE_W*i +: BYTE_W])
      );
    end
  endgenerate

  // Inverse column mix, one unit per column
  generate
    for (genvar c = 0; c < COLS; c++) begin : g_mix
      aes_inv_mixcol u_mix (
        .col_in  (subbed[COL_W*c +: COL_W]),
        .col_out (mixed[COL_W*c +: COL_W])
      );
    end
  endgenerate

  // Key addition is the final step of the round
  always_comb begin
    round_low = (in_final ? subbed : mixed) ^ in_key;
    upper_d   = in_zero_upper ? '0 : in_prior[DEST_W-1:BLOCK_W];
  end

  // Next-state
  always_comb begin
    valid_d = in_valid;
    res_d   = res_q;
    if (in_valid) res_d = {upper_d, round_low};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) res_q <= res_d;
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_UPPER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_zero_upper) |=> (out_result[255:128] == $past(in_prior[255:128]))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zero_upper) |=> (out_result[255:128] == '0)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R8

endmodule

// File: tb/sim_aes_inv_round.sv
module sim_aes_inv_round;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  localparam logic [127:0] VEC_STATE [NVEC] = '{
    128'h00000000000000000000000000000000,
    128'h0f0e0d0c0b0a09080706050403020100,
    128'h69c4e0d86a7b0430d8cdb78070b4c55a,
    128'hffffffffffffffffffffffffffffffff,
    128'h0123456789abcdeffedcba9876543210,
    128'h3925841d02dc09fbdc118597196a0b32,
    128'h63636363636363636363636363636363,
    128'h80402010080402018040201008040201
  };
  localparam logic [127:0] VEC_KEY [NVEC] = '{
    128'h0,
    128'h13111d7fe3944a17f307a78b4d2b30c5,
    128'h000102030405060708090a0b0c0d0e0f,
    128'hffffffffffffffffffffffffffffffff,
    128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
    128'h0,
    128'hdeadbeef00112233445566778899aabb
  };
  localparam logic VEC_FINAL [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic VEC_ZERO  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_final;
  logic         in_zero_upper;
  logic [127:0] in_state;
  logic [127:0] in_key;
  logic [255:0] in_prior;
  logic         out_valid;
  logic [255:0] out_result;

  int n_checks;
  int n_fail;
  bit finished;
  logic [7:0] inv_tab [256];

  aes_inv_round u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_final      (in_final),
    .in_zero_upper (in_zero_upper),
    .in_state      (in_state),
    .in_key        (in_key),
    .in_prior      (in_prior),
    .out_valid     (out_valid),
    .out_result    (out_result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_xt(input logic [7:0] a);
    m_xt = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 0; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = m_xt(x);
    end
    m_mul = p;
  endfunction

  function automatic logic [7:0] m_rl(input logic [7:0] a, input int n);
    m_rl = (a << n) | (a >> (8 - n));
  endfunction

  // Forward S-box: brute-force inverse, then forward affine
  function automatic logic [7:0] m_fwd_sbox(input logic [7:0] x);
    logic [7:0] inv;
    inv = 0;
    for (int y = 1; y < 256; y++)
      if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    m_fwd_sbox = inv ^ m_rl(inv,1) ^ m_rl(inv,2) ^ m_rl(inv,3) ^ m_rl(inv,4) ^ 8'h63;
  endfunction

  function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k,
                                           input logic fin);
    logic [7:0] a [16];
    logic [7:0] b [16];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        a[4*c+r] = inv_tab[s[8*(4*((c-r+4)%4)+r) +: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        b[4*c+r] = fin ? a[4*c+r] :
                   (m_mul(a[4*c+r], 8'h0E) ^ m_mul(a[4*c+(r+1)%4], 8'h0B) ^
                    m_mul(a[4*c+(r+2)%4], 8'h0D) ^ m_mul(a[4*c+(r+3)%4], 8'h09));
    for (int i = 0; i < 16; i++) o[8*i +: 8] = b[i];
    m_round = o ^ k;
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] s, input logic [127:0] k, input logic fin,
                       input logic zu, input logic [255:0] prior);
    @(negedge clk);
    in_state = s; in_key = k; in_final = fin; in_zero_upper = zu; in_prior = prior;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [255:0] expect_full(input logic [127:0] s, input logic [127:0] k,
                                               input logic fin, input logic zu,
                                               input logic [255:0] prior);
    expect_full = {zu ? 128'h0 : prior[255:128], m_round(s, k, fin)};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [255:0] prior;
    logic [255:0] held;
    logic [127:0] r_a, r_b;
    n_checks = 0; n_fail = 0; finished = 0;
    for (int y = 0; y < 256; y++) inv_tab[m_fwd_sbox(8'(y))] = 8'(y);

    rst_n = 1'b0; in_valid = 1'b1; in_final = 0; in_zero_upper = 0;
    in_state = '0; in_key = '0; in_prior = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset holds out_valid low", {255'h0, out_valid}, 256'h0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle out_valid low", {255'h0, out_valid}, 256'h0);

    // Vector table, walked by one loop (R3 R4 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      prior = {VEC_STATE[(v+3)%NVEC], VEC_KEY[(v+5)%NVEC]} ^ {8{32'(v * 32'h9e3779b9)}};
      apply(VEC_STATE[v], VEC_KEY[v], VEC_FINAL[v], VEC_ZERO[v], prior);
      chk("R1 out_valid after capture", {255'h0, out_valid}, {255'h0, 1'b1});
      chk(VEC_FINAL[v] ? "R4 final round result" : "R3 normal round result",
          out_result, expect_full(VEC_STATE[v], VEC_KEY[v], VEC_FINAL[v], VEC_ZERO[v], prior));
      chk(VEC_ZERO[v] ? "R6 upper zeroed" : "R5 upper merged",
          {128'h0, out_result[255:128]}, {128'h0, VEC_ZERO[v] ? 128'h0 : prior[255:128]});
    end

    // R7 known answer: zero state, zero key -> 0x52 everywhere
    apply('0, '0, 1'b0, 1'b1, '1);
    chk("R7 known answer normal", out_result, {128'h0, {16{8'h52}}});
    apply('0, '0, 1'b1, 1'b1, '1);
    chk("R7 known answer final", out_result, {128'h0, {16{8'h52}}});

    // R3 row shift direction: only byte 1 (row 1, col 0) nonzero, final variant
    apply(128'h0000_0000_0000_0000_0000_0000_0000_6300, '0, 1'b1, 1'b1, '0);
    chk("R3 row 1 byte moves to column 1",
        {128'h0, out_result[127:0]}, {128'h0, {16{8'h52}} & ~(128'hff << 40)});

    // R8 hold while idle and inputs change
    apply(VEC_STATE[2], VEC_KEY[2], 1'b0, 1'b0, {8{32'hcafef00d}});
    held = out_result;
    @(negedge clk);
    in_state = ~in_state; in_key = ~in_key; in_prior = ~in_prior; in_zero_upper = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 result held while idle", out_result, held);
    chk("R1 out_valid low while idle", {255'h0, out_valid}, 256'h0);

    // R9 key linearity
    apply(VEC_STATE[5], 128'h0, 1'b0, 1'b1, '0);
    r_a = out_result[127:0];
    apply(VEC_STATE[5], 128'h8000_0000_0000_0001_00ff_0000_1234_5678, 1'b0, 1'b1, '0);
    r_b = out_result[127:0];
    chk("R9 key added last", {128'h0, r_a ^ r_b},
        {128'h0, 128'h8000_0000_0000_0001_00ff_0000_1234_5678});

    // R2 reset overrides a pending capture
    @(negedge clk);
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 reset overrides capture", {255'h0, out_valid}, 256'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule